// File: doc/BRIEF.md
# DAC Sleep Wake Sequencer

This block manages power for an analog output converter cell. It watches a request FIFO that sits outside the block. When a request is waiting and the cell is unpowered, it raises the power enable and counts a programmable start-up delay. It then issues conversions one at a time: each conversion strobe carries the channel of the FIFO head entry, and that entry is popped when its conversion finishes. Once the FIFO runs dry, the block powers the cell down again.

Two options change this flow. The sleep enable controls whether the cell is ever powered down. With sleep disabled, the cell stays powered after the first start-up, so later requests skip the delay. The fast wake-up option makes the idle state a partial standby instead of fully off. Waking from standby uses a start-up count four times shorter: the programmed value shifted right by two.

Top module: `dac_wake_seq`

## Requirements
- R1: While reset is asserted and just after it is released, pwr_en, stby, conv_strobe, fifo_pop and busy are all 0.
- R2: When pwr_en is 0 and fifo_empty is 0 at a clock edge, pwr_en is 1 after that edge.
- R3: When waking from fully off, the first conv_strobe comes exactly N+1 cycles after the cycle in which pwr_en rose, where N is startup_cnt.
- R4: With sleep_en=1 and fast_wake=1, the idle cell rests in standby (stby=1, pwr_en=0). A wake from standby gives its first conv_strobe (N>>2)+1 cycles after pwr_en rose.
- R5: Each conversion takes C cycles, where C is conv_cycles, or 1 when conv_cycles is 0. conv_strobe is a one-cycle pulse in the first cycle and fifo_pop is a one-cycle pulse in the last. Within a burst, successive strobes are C+1 cycles apart.
- R6: conv_chan during a strobe equals the channel of the FIFO head entry that the conversion serves. Conversions follow FIFO order.
- R7: With sleep_en=1, when the last entry is popped, pwr_en falls 2 cycles after the pop cycle.
- R8: With sleep_en=0, pwr_en never falls once it is high. A request that arrives while the cell is powered and idle is strobed 1 cycle after fifo_empty falls, with no start-up wait.
- R9: pwr_en and stby are never both 1. busy is 1 during the start-up wait and during conversions, and 0 whenever pwr_en is 0.
- R10: With sleep_en=1 and fast_wake=0, the idle cell is fully off (stby=0, pwr_en=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_en | input | 1 | Power the cell down when no requests remain |
| fast_wake | input | 1 | Idle in partial standby with the shortened wait |
| startup_cnt | input | STARTUP_W (8) | Full start-up wait in cycles |
| conv_cycles | input | CONV_W (8) | Cycles per conversion (0 is treated as 1) |
| fifo_empty | input | 1 | Request FIFO holds no entry |
| fifo_chan | input | CHAN_W (2) | Channel of the FIFO head entry |
| fifo_pop | output | 1 | Remove the head entry (last cycle of a conversion) |
| pwr_en | output | 1 | Full power enable for the analog cell |
| stby | output | 1 | Partial standby enable for the analog cell |
| conv_strobe | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | CHAN_W (2) | Channel of the current conversion |
| busy | output | 1 | Start-up wait or conversion in progress |

## Verification
The hardest situation to reach is a wake from partial standby. The bench must turn fast wake-up on while the cell is idle and let the sequencer settle into standby. Only then does it push requests, so that the shortened wait is measured from a real standby state rather than a fully-off one. A second hard case is a request arriving to a powered but idle cell with sleep disabled. The bench drains a burst with sleep off, lets the cell stay powered for many cycles, then pushes a single entry and times its strobe against the push.

// File: rtl/dws_pkg.sv
package dws_pkg;
   typedef enum logic [2:0] {
      DWS_OFF   = 3'd0,
      DWS_STBY  = 3'd1,
      DWS_WAIT  = 3'd2,
      DWS_CONV  = 3'd3,
      DWS_CHECK = 3'd4
   } dws_state_e;
endpackage

// File: rtl/dws_down_ctr.sv
module dws_down_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (dec && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/dws_fsm.sv
module dws_fsm
   import dws_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sleep_en,
   input  logic       fast_wake,
   input  logic       fifo_empty,
   input  logic       wait_done,
   input  logic       conv_done,
   output dws_state_e state,
   output logic       enter_wait,
   output logic       enter_conv,
   output logic       short_wait
);
   dws_state_e nxt;

   always_comb begin
      nxt        = state;
      enter_wait = 1'b0;
      enter_conv = 1'b0;
      short_wait = 1'b0;
      unique case (state)
         DWS_OFF: begin
            if (!fifo_empty) begin
               nxt        = DWS_WAIT;
               enter_wait = 1'b1;
            end else if (fast_wake) begin
               nxt = DWS_STBY;
            end
         end
         DWS_STBY: begin
            if (!fifo_empty) begin
               nxt        = DWS_WAIT;
               enter_wait = 1'b1;
               short_wait = 1'b1;
            end else if (!fast_wake) begin
               nxt = DWS_OFF;
            end
         end
         DWS_WAIT: begin
            if (wait_done) begin
               nxt        = DWS_CONV;
               enter_conv = 1'b1;
            end
         end
         DWS_CONV: begin
            if (conv_done)
               nxt = DWS_CHECK;
         end
         DWS_CHECK: begin
            if (!fifo_empty) begin
               nxt        = DWS_CONV;
               enter_conv = 1'b1;
            end else if (sleep_en) begin
               nxt = fast_wake ? DWS_STBY : DWS_OFF;
            end
         end
         default: nxt = DWS_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= DWS_OFF;
      else
         state <= nxt;
   end
endmodule

// File: rtl/dac_wake_seq.sv
module dac_wake_seq
   import dws_pkg::*;
#(
   parameter int STARTUP_W  = 8,
   parameter int CONV_W     = 8,
   parameter int CHAN_W     = 2,
   parameter int FAST_SHIFT = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sleep_en,
   input  logic                 fast_wake,
   input  logic [STARTUP_W-1:0] startup_cnt,
   input  logic [CONV_W-1:0]    conv_cycles,
   input  logic                 fifo_empty,
   input  logic [CHAN_W-1:0]    fifo_chan,
   output logic                 fifo_pop,
   output logic                 pwr_en,
   output logic                 stby,
   output logic                 conv_strobe,
   output logic [CHAN_W-1:0]    conv_chan,
   output logic                 busy
);
   localparam logic [CONV_W-1:0] CONV_ONE = CONV_W'(1);

   if (STARTUP_W < 1 || CONV_W < 1 || CHAN_W < 1) begin : g_bad_width
      $error("dac_wake_seq: widths must be at least 1");
   end
   if (FAST_SHIFT < 0 || FAST_SHIFT >= STARTUP_W) begin : g_bad_shift
      $error("dac_wake_seq: FAST_SHIFT must lie in 0..STARTUP_W-1");
   end

   dws_state_e state;
   logic enter_wait, enter_conv, short_wait;
   logic wait_done, conv_done;
   logic [STARTUP_W-1:0] wait_val;
   logic [CONV_W-1:0]    conv_val;
   logic                 strobe_q;
   logic [CHAN_W-1:0]    chan_q;

   dws_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_en   (sleep_en),
      .fast_wake  (fast_wake),
      .fifo_empty (fifo_empty),
      .wait_done  (wait_done),
      .conv_done  (conv_done),
      .state      (state),
      .enter_wait (enter_wait),
      .enter_conv (enter_conv),
      .short_wait (short_wait)
   );

   if (FAST_SHIFT == 0) begin : g_no_shorten
      assign wait_val = startup_cnt;
   end else begin : g_shorten
      assign wait_val = short_wait ? (startup_cnt >> FAST_SHIFT) : startup_cnt;
   end

   assign conv_val = (conv_cycles == '0) ? '0 : (conv_cycles - CONV_ONE);

   dws_down_ctr #(.W(STARTUP_W)) u_wait_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter_wait),
      .load_val (wait_val),
      .dec      (state == DWS_WAIT),
      .zero     (wait_done)
   );

   dws_down_ctr #(.W(CONV_W)) u_conv_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (enter_conv),
      .load_val (conv_val),
      .dec      (state == DWS_CONV),
      .zero     (conv_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         chan_q   <= '0;
      end else begin
         strobe_q <= enter_conv;
         if (enter_conv)
            chan_q <= fifo_chan;
      end
   end

   assign conv_strobe = strobe_q;
   assign conv_chan   = chan_q;
   assign fifo_pop    = (state == DWS_CONV) && conv_done;
   assign pwr_en      = (state == DWS_WAIT) || (state == DWS_CONV) || (state == DWS_CHECK);
   assign stby        = (state == DWS_STBY);
   assign busy        = (state == DWS_WAIT) || (state == DWS_CONV);
endmodule

// File: rtl/dws_checker.sv
module dws_checker (
   input logic clk,
   input logic rst_n,
   input logic sleep_en,
   input logic fifo_empty,
   input logic fifo_pop,
   input logic pwr_en,
   input logic stby,
   input logic conv_strobe,
   input logic busy
);
   AST_WAKE_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!pwr_en && !fifo_empty) |=> pwr_en);  // R2
   AST_STROBE_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |-> (pwr_en && busy));  // R3
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_strobe |=> !conv_strobe);  // R5
   AST_POP_IN_CONV: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (busy && pwr_en));  // R5
   AST_DOWN_WHEN_DRY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en) |-> ($past(fifo_empty) && $past(sleep_en)));  // R7
   AST_AWAKE_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep_en && pwr_en) |=> pwr_en);  // R8
   AST_PWR_STBY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwr_en && stby));  // R9
   AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> !busy);  // R9
endmodule

bind dac_wake_seq dws_checker u_dws_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .sleep_en    (sleep_en),
   .fifo_empty  (fifo_empty),
   .fifo_pop    (fifo_pop),
   .pwr_en      (pwr_en),
   .stby        (stby),
   .conv_strobe (conv_strobe),
   .busy        (busy)
);

// File: tb/dac_wake_seq_test.sv
`timescale 1ns/1ps
module dac_wake_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_en = 1'b1;
   logic       fast_wake = 1'b0;
   logic [7:0] startup_cnt = 8'd10;
   logic [7:0] conv_cycles = 8'd3;
   logic       fifo_empty = 1'b1;
   logic [1:0] fifo_chan = 2'd0;
   logic       fifo_pop, pwr_en, stby, conv_strobe, busy;
   logic [1:0] conv_chan;

   always #4 clk = ~clk;   // 125 MHz

   dac_wake_seq uut (
      .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en), .fast_wake(fast_wake),
      .startup_cnt(startup_cnt), .conv_cycles(conv_cycles),
      .fifo_empty(fifo_empty), .fifo_chan(fifo_chan), .fifo_pop(fifo_pop),
      .pwr_en(pwr_en), .stby(stby), .conv_strobe(conv_strobe),
      .conv_chan(conv_chan), .busy(busy)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [1:0] fifo_q[$];
   logic [1:0] exp_q[$];
   int   exp_wait = 10;
   int   push_cyc = 0, rise_cyc = 0, strobe_cyc = 0, pop_cyc = 0;
   bit   rise_pending = 0, burst_cont = 0, prev_pwr = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int conv_len();
      return (conv_cycles == 0) ? 1 : int'(conv_cycles);
   endfunction

   function automatic void refresh();
      fifo_empty = (fifo_q.size() == 0);
      fifo_chan  = (fifo_q.size() == 0) ? 2'd0 : fifo_q[0];
   endfunction

   always @(posedge clk) cyc <= cyc + 1;

   // driver: pushes a request and its expected result into the scoreboard
   task automatic push(input logic [1:0] ch);
      @(posedge clk); #1;
      if (fifo_q.size() == 0) push_cyc = cyc;
      fifo_q.push_back(ch);
      exp_q.push_back(ch);
      refresh();
   endtask

   task automatic wait_drain();
      while (exp_q.size() != 0) @(posedge clk);
      repeat (6) @(posedge clk);
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n) begin
         chk(!(pwr_en && stby), "R9 pwr_en/stby exclusive", int'(stby), 0);
         if (!pwr_en && busy) chk(0, "R9 busy while unpowered", 1, 0);
         if (pwr_en && !prev_pwr) begin
            chk(cyc - push_cyc == 1, "R2 wake latency", cyc - push_cyc, 1);
            rise_pending = 1;
            rise_cyc = cyc;
         end
         if (conv_strobe) begin
            chk(busy, "R9 busy during conversion", int'(busy), 1);
            if (exp_q.size() == 0) chk(0, "R6 unexpected strobe", int'(conv_chan), -1);
            else begin
               logic [1:0] e;
               e = exp_q.pop_front();
               chk(conv_chan == e, "R6 channel order", int'(conv_chan), int'(e));
            end
            if (rise_pending)
               chk(cyc - rise_cyc == exp_wait + 1, "R3/R4 start-up wait",
                   cyc - rise_cyc, exp_wait + 1);
            else if (burst_cont)
               chk(cyc - strobe_cyc == conv_len() + 1, "R5 strobe spacing",
                   cyc - strobe_cyc, conv_len() + 1);
            else if (!sleep_en)
               chk(cyc - push_cyc == 1, "R8 no wait when powered",
                   cyc - push_cyc, 1);
            rise_pending = 0;
            strobe_cyc = cyc;
         end
         if (fifo_pop) begin
            chk(cyc - strobe_cyc == conv_len() - 1, "R5 pop in last cycle",
                cyc - strobe_cyc, conv_len() - 1);
            if (fifo_q.size() != 0) void'(fifo_q.pop_front());
            refresh();
            burst_cont = (fifo_q.size() != 0);
            pop_cyc = cyc;
         end
         if (!pwr_en && prev_pwr) begin
            chk(cyc - pop_cyc == 2, "R7 power-down delay", cyc - pop_cyc, 2);
            chk(stby == fast_wake, "R4/R10 idle state stby", int'(stby), int'(fast_wake));
            burst_cont = 0;
         end
         prev_pwr = pwr_en;
      end
   end

   bit done = 0;
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!pwr_en && !stby && !conv_strobe && !fifo_pop && !busy,
          "R1 outputs in reset", int'({pwr_en, stby, conv_strobe, fifo_pop, busy}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!pwr_en && !stby && !busy, "R1 outputs after release",
          int'({pwr_en, stby, busy}), 0);

      // full wake from off, three requests
      exp_wait = 10;
      push(2'd1); push(2'd2); push(2'd3);
      wait_drain();
      @(negedge clk);
      chk(!pwr_en && !stby, "R10 idle fully off", int'({pwr_en, stby}), 0);

      // fast wake-up from standby
      @(posedge clk); #1 fast_wake = 1'b1; conv_cycles = 8'd1;
      repeat (5) @(negedge clk);
      chk(stby && !pwr_en, "R4 standby while idle", int'({stby, pwr_en}), 2);
      exp_wait = 10 >> 2;
      push(2'd0); push(2'd3);
      wait_drain();

      // shortened wait with odd count, zero conversion length
      @(posedge clk); #1 startup_cnt = 8'd13; conv_cycles = 8'd0;
      repeat (3) @(posedge clk);
      exp_wait = 13 >> 2;
      push(2'd2); push(2'd1); push(2'd0); push(2'd3);
      wait_drain();
      @(negedge clk);
      chk(stby && !pwr_en, "R4 back to standby", int'({stby, pwr_en}), 2);

      // sleep disabled: stays powered, later request without wait
      @(posedge clk); #1 sleep_en = 1'b0; fast_wake = 1'b0;
      startup_cnt = 8'd5; conv_cycles = 8'd2;
      repeat (4) @(posedge clk);
      exp_wait = 5;
      push(2'd1);
      wait_drain();
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk(pwr_en && !stby, "R8 stays powered", int'({pwr_en, stby}), 2);
      push(2'd2); push(2'd0);
      wait_drain();
      @(negedge clk);
      chk(pwr_en, "R8 powered after second burst", int'(pwr_en), 1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule